// File: doc/BRIEF.md
# Display Dimmer Timeout Controller

This block decides, once per clock, how a display panel should be lit. It has two one-cycle pulse inputs: a power-button press and a touch-activity event. Button debouncing and edge detection happen upstream. The block drives two registered Moore outputs. One says whether the panel is lit. The other says whether it is lit at full rather than half brightness.

After reset the panel is dark. A power press lights it at full brightness. While the panel is lit, an idle counter inside the block counts consecutive cycles that have no touch and no press. A long enough idle run at full brightness dims the panel to half. A further idle run at half brightness switches the panel off. A touch while dimmed brings back full brightness. A power press while lit always turns the panel off. Both idle thresholds are parameters.

Top module: `dimmer_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `display_on` and `full_bright` are both 0.
- R2: A cycle with `power_press` high while the display is off makes `display_on`=1 and `full_bright`=1 on the next cycle.
- R3: A cycle with `power_press` high while the display is on, at either brightness, makes both outputs 0 on the next cycle.
- R4: At full brightness, idle cycles (no touch and no press) are counted. The panel stays at full brightness through DIM_IDLE (default 3) idle cycles and drops to half brightness (`display_on`=1, `full_bright`=0) on the cycle after idle cycle number DIM_IDLE+1.
- R5: At half brightness, the panel switches off on the cycle after idle cycle number OFF_IDLE (default 3). It stays at half brightness after fewer idle cycles.
- R6: A touch without a press while at half brightness makes `full_bright`=1 on the next cycle.
- R7: A touch at full brightness restarts the idle count, so the full DIM_IDLE+1 idle cycles are needed again before the panel dims.
- R8: When `power_press` and `touch` are both high in one cycle, the press alone decides the next state.
- R9: While the display is off, `touch` has no effect and the display stays off.
- R10: The outputs are registered, `full_bright`=1 never occurs with `display_on`=0, and both outputs are 0 when the display is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| power_press | input | 1 | One-cycle power-button pulse |
| touch | input | 1 | One-cycle touch-activity pulse |
| display_on | output | 1 | Panel is lit |
| full_bright | output | 1 | Panel is lit at full brightness |

## Verification
The hardest state to reach from the ports is the automatic switch-off. It needs DIM_IDLE+1 idle cycles and then OFF_IDLE more, with no touch and no press anywhere in between. Uniform random pulses almost never produce a run that long. The stimulus therefore forces long idle runs in directed sequences, including runs cut one cycle short of each threshold. The random phase keeps press and touch rare, so idle runs of realistic length still occur, and every cycle is compared with a reference model in the bench.

// File: rtl/dimmer_pkg.sv
// Shared types for the display dimmer controller.
// Assumes a two-bit state code is enough for the three panel modes.
package dimmer_pkg;

    typedef enum logic [1:0] {
        DIM_OFF  = 2'b00,
        DIM_FULL = 2'b01,
        DIM_HALF = 2'b10
    } dim_state_e;

endpackage

// File: rtl/dimmer_idle_timer.sv
// Idle-cycle counter for the dimmer controller.
// Assumes clear takes priority over increment and that the controller
// never increments past the larger threshold.
module dimmer_idle_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    // Count idle cycles; clear on any event or mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/dimmer_next_state.sv
// Combinational transition logic for the dimmer controller.
// Assumes one-cycle input pulses. A power press wins over a touch.
// The timeouts are "more than DIM_IDLE" idle cycles at full brightness
// and OFF_IDLE idle cycles at half brightness.
module dimmer_next_state
    import dimmer_pkg::*;
#(
    parameter int DIM_IDLE = 3,
    parameter int OFF_IDLE = 3,
    parameter int CW       = 2
) (
    input  dim_state_e    cur,
    input  logic          power_press,
    input  logic          touch,
    input  logic [CW-1:0] cnt,
    output dim_state_e    nxt,
    output logic          clr,
    output logic          inc
);

    localparam logic [CW-1:0] DIM_LAST = CW'(DIM_IDLE);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_IDLE - 1);

    // Pick the next mode and tell the idle timer what to do.
    always_comb begin
        nxt = cur;
        clr = 1'b1;
        inc = 1'b0;
        unique case (cur)
            DIM_OFF: begin
                if (power_press) nxt = DIM_FULL;
            end
            DIM_FULL: begin
                if (power_press) begin
                    nxt = DIM_OFF;
                end else if (touch) begin
                    nxt = DIM_FULL;
                end else if (cnt == DIM_LAST) begin
                    nxt = DIM_HALF;
                end else begin
                    clr = 1'b0;
                    inc = 1'b1;
                end
            end
            DIM_HALF: begin
                if (power_press) begin
                    nxt = DIM_OFF;
                end else if (touch) begin
                    nxt = DIM_FULL;
                end else if (cnt == OFF_LAST) begin
                    nxt = DIM_OFF;
                end else begin
                    clr = 1'b0;
                    inc = 1'b1;
                end
            end
            default: nxt = DIM_OFF;
        endcase
    end

endmodule

// File: rtl/dimmer_out_reg.sv
// Registered Moore outputs for the dimmer controller.
// Assumes the next mode is given, so the outputs line up with the mode register.
module dimmer_out_reg
    import dimmer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dim_state_e nxt,
    output logic       display_on,
    output logic       full_bright
);

    // Decode the next mode into the lit and full-brightness flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            display_on  <= 1'b0;
            full_bright <= 1'b0;
        end else begin
            display_on  <= (nxt != DIM_OFF);
            full_bright <= (nxt == DIM_FULL);
        end
    end

endmodule

// File: rtl/dimmer_ctrl.sv
// Display dimmer timeout controller, top level.
// Holds the mode register and connects the idle timer, the transition
// logic and the output flops. Assumes debounced one-cycle pulses and
// thresholds of at least 1.
module dimmer_ctrl
    import dimmer_pkg::*;
#(
    parameter int DIM_IDLE = 3,
    parameter int OFF_IDLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_press,
    input  logic touch,
    output logic display_on,
    output logic full_bright
);

    localparam int MAX_IDLE = (DIM_IDLE > OFF_IDLE) ? DIM_IDLE : OFF_IDLE;
    localparam int CW       = (MAX_IDLE < 2) ? 1 : $clog2(MAX_IDLE + 1);

    dim_state_e    state;
    dim_state_e    state_nxt;
    logic          idle_clr;
    logic          idle_inc;
    logic [CW-1:0] idle_cnt;

    // Mode register, dark after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DIM_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    dimmer_idle_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_clr),
        .inc   (idle_inc),
        .cnt   (idle_cnt)
    );

    dimmer_next_state #(
        .DIM_IDLE (DIM_IDLE),
        .OFF_IDLE (OFF_IDLE),
        .CW       (CW)
    ) u_next (
        .cur         (state),
        .power_press (power_press),
        .touch       (touch),
        .cnt         (idle_cnt),
        .nxt         (state_nxt),
        .clr         (idle_clr),
        .inc         (idle_inc)
    );

    dimmer_out_reg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .nxt         (state_nxt),
        .display_on  (display_on),
        .full_bright (full_bright)
    );

endmodule

// File: rtl/dimmer_ctrl_checks.sv
// Property checker for dimmer_ctrl, attached by bind.
// Assumes it sees the top ports and the idle counter.
module dimmer_ctrl_checks #(
    parameter int DIM_IDLE = 3,
    parameter int OFF_IDLE = 3,
    parameter int CW       = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          power_press,
    input logic          touch,
    input logic          display_on,
    input logic          full_bright,
    input logic [CW-1:0] idle_cnt
);

    // R2: a press while dark lights the panel at full brightness.
    p_press_lights_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!display_on && power_press) |=> (display_on && full_bright));

    // R3 and R8: a press while lit turns the panel off, whatever touch does.
    p_press_darkens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (display_on && power_press) |=> !display_on);

    // R4: the last allowed idle cycle at full brightness dims the panel.
    p_dim_on_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_bright && !power_press && !touch && idle_cnt == CW'(DIM_IDLE))
        |=> (display_on && !full_bright));

    // R5: the last allowed idle cycle at half brightness darkens the panel.
    p_off_on_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (display_on && !full_bright && !power_press && !touch
         && idle_cnt == CW'(OFF_IDLE - 1)) |=> !display_on);

    // R6: a touch while dimmed restores full brightness.
    p_touch_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (display_on && !full_bright && touch && !power_press) |=> full_bright);

    // R7: a touch at full brightness restarts the idle count.
    p_touch_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_bright && touch && !power_press) |=> (idle_cnt == '0));

    // R9: a touch alone never lights a dark panel.
    p_dark_ignores_touch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!display_on && !power_press) |=> !display_on);

    // R10: full brightness only while lit.
    p_full_implies_lit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_bright |-> display_on);

endmodule

bind dimmer_ctrl dimmer_ctrl_checks #(
    .DIM_IDLE (DIM_IDLE),
    .OFF_IDLE (OFF_IDLE),
    .CW       (CW)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .power_press (power_press),
    .touch       (touch),
    .display_on  (display_on),
    .full_bright (full_bright),
    .idle_cnt    (idle_cnt)
);

// File: tb/dimmer_ctrl_test.sv
// Self-checking bench for dimmer_ctrl: directed corners plus seeded random pulses.
module dimmer_ctrl_test;

    localparam int DIM_IDLE = 3;
    localparam int OFF_IDLE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic power_press = 1'b0;
    logic touch = 1'b0;
    logic display_on;
    logic full_bright;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model: 0 dark, 1 full, 2 half.
    int m_mode = 0;
    int m_idle = 0;

    always #5 clk = ~clk;

    dimmer_ctrl #(.DIM_IDLE(DIM_IDLE), .OFF_IDLE(OFF_IDLE)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .power_press (power_press),
        .touch       (touch),
        .display_on  (display_on),
        .full_bright (full_bright)
    );

    function automatic int exp_on(input int mode);
        return (mode != 0) ? 1 : 0;
    endfunction

    function automatic int exp_full(input int mode);
        return (mode == 1) ? 1 : 0;
    endfunction

    // Advance the model by one cycle, working from the requirements.
    task automatic model_step(input bit p, input bit t);
        if (m_mode == 0) begin
            if (p) m_mode = 1;
            m_idle = 0;
        end else if (p) begin
            m_mode = 0; m_idle = 0;
        end else if (t) begin
            m_mode = 1; m_idle = 0;
        end else begin
            m_idle = m_idle + 1;
            if (m_mode == 1 && m_idle > DIM_IDLE) begin
                m_mode = 2; m_idle = 0;
            end else if (m_mode == 2 && m_idle >= OFF_IDLE) begin
                m_mode = 0; m_idle = 0;
            end
        end
    endtask

    task automatic check(input string req);
        checks++;
        if (display_on !== exp_on(m_mode)[0] || full_bright !== exp_full(m_mode)[0]) begin
            fails++;
            $display("FAIL %s: on/full actual %b%b expected %0d%0d",
                     req, display_on, full_bright, exp_on(m_mode), exp_full(m_mode));
        end
    endtask

    // Drive one cycle at the falling edge, then compare at the next falling edge.
    task automatic step(input bit p, input bit t, input string req);
        power_press = p;
        touch = t;
        @(posedge clk);
        model_step(p, t);
        @(negedge clk);
        check(req);
    endtask

    task automatic idle_run(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd48879));
        @(negedge clk);
        @(negedge clk);
        check("R1 during reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0, "R1 after release");

        // R9: touch while dark does nothing.
        step(1'b0, 1'b1, "R9");
        step(1'b0, 1'b1, "R9");
        // R2: press lights at full.
        step(1'b1, 1'b0, "R2");
        // R4: three idle cycles keep full, the fourth dims.
        idle_run(DIM_IDLE, "R4 below threshold");
        step(1'b0, 1'b0, "R4 dim");
        // R6: touch while dimmed restores full.
        step(1'b0, 1'b1, "R6");
        // R7: touch part way through the run restarts the count.
        idle_run(DIM_IDLE - 1, "R7");
        step(1'b0, 1'b1, "R7 touch");
        idle_run(DIM_IDLE, "R7 still full");
        step(1'b0, 1'b0, "R7 dim after full run");
        // R5: one short of the half timeout, then touch, then the full timeout.
        idle_run(OFF_IDLE - 1, "R5 below threshold");
        step(1'b0, 1'b1, "R6 late touch");
        idle_run(DIM_IDLE + 1, "R4 dim again");
        idle_run(OFF_IDLE, "R5 off");
        step(1'b0, 1'b0, "R10 dark stays dark");
        // R8: press and touch together while dark lights the panel.
        step(1'b1, 1'b1, "R8 from dark");
        // R8 and R3: press and touch together at full turn it off.
        step(1'b1, 1'b1, "R8 from full");
        // R3: press while dimmed turns it off.
        step(1'b1, 1'b0, "R2 relight");
        idle_run(DIM_IDLE + 1, "R4 to half");
        step(1'b1, 1'b0, "R3 from half");
        // R8: press and touch together while dimmed turn it off.
        step(1'b1, 1'b0, "R2 relight");
        idle_run(DIM_IDLE + 1, "R4 to half");
        step(1'b1, 1'b1, "R8 from half");

        // Random phase with rare pulses so long idle runs occur.
        for (int i = 0; i < 3000; i++) begin
            bit p = (($urandom % 30) == 0);
            bit t = (($urandom % 7) == 0);
            step(p, t, "R10 random");
        end

        // R1: reset from a lit state.
        step(1'b1, 1'b0, "R2 before reset");
        if (m_mode == 0) step(1'b1, 1'b0, "R2 before reset");
        rst_n = 1'b0;
        @(posedge clk);
        m_mode = 0; m_idle = 0;
        @(negedge clk);
        check("R1 reset while lit");
        rst_n = 1'b1;
        step(1'b0, 1'b0, "R1 after second release");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule